// File: doc/BRIEF.md
# Descriptor Ring Channel Status Tracker

This block decides whether one DMA channel of a network interface is running. The channel works through a circular array of descriptors in memory. Software enables the channel with a control bit and moves a produce index. The data mover moves a consume index and signals when it begins a frame and when that frame's data and status have reached memory. A build parameter selects the direction. A transmit channel runs while descriptors are waiting (the ring is not empty). A receive channel runs while free descriptors remain (the ring is not full). The channel does not stop in the middle of a frame. Once a frame has begun, the channel stays active until that frame is committed, even if software clears the enable bit or the ring drains or fills first.

The block also holds the two base-address registers for the channel: one for the descriptor array and one for the status array. Their low address bits are forced to zero so that they are word aligned and double-word aligned.

Top module: `ring_chan_status`

## Requirements
- R1: After reset, `chan_active` is 0, `in_frame` is 0 and both base-address outputs are 0.
- R2: With direction transmit, enable high and no frame open, `chan_active` is 1 one clock edge after `prod_idx` differs from `cons_idx`, and 0 one edge after they are equal.
- R3: With direction receive, enable high and no frame open, `chan_active` is 0 one edge after `prod_idx` equals `cons_idx - 1`, and 1 otherwise. When `cons_idx` is 0, the value `cons_idx - 1` wraps to `ring_len - 1`.
- R4: With enable low and no frame open or starting, `chan_active` is 0 after the next edge, whatever the indices are.
- R5: A `frame_start` pulse opens a frame. While a frame is open, `chan_active` stays 1 even with enable low.
- R6: A `frame_commit` pulse closes the open frame, and `chan_active` then follows R2 to R4 from the same edge. When `frame_start` and `frame_commit` are high in the same cycle, the frame stays open.
- R7: On a transmit channel, if the ring becomes empty while a frame is open, `chan_active` stays 1 until the commit edge and drops on that edge.
- R8: A write to the descriptor base stores bits 31:2 of the written data. Bits 1:0 of `desc_base` always read 0.
- R9: A write to the status base stores bits 31:3 of the written data. Bits 2:0 of `stat_base` always read 0.
- R10: A base register keeps its value when it is not written. A write to one base register does not change the other.
- R11: `chan_active` is registered. A change on an input has no effect on the output before the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sw_enable | input | 1 | Channel enable set by software |
| prod_idx | input | IDX_W | Produce index |
| cons_idx | input | IDX_W | Consume index |
| ring_len | input | IDX_W+1 | Number of descriptors in the ring (at least 2) |
| frame_start | input | 1 | Pulse: the data mover has begun a frame |
| frame_commit | input | 1 | Pulse: the frame's data and status are in memory |
| desc_base_we | input | 1 | Write strobe for the descriptor base |
| stat_base_we | input | 1 | Write strobe for the status base |
| base_wdata | input | ADDR_W | Write data for the base registers |
| chan_active | output | 1 | Registered channel status |
| in_frame | output | 1 | A frame is open |
| desc_base | output | ADDR_W | Descriptor array base, word aligned |
| stat_base | output | ADDR_W | Status array base, double-word aligned |

## Verification
The hardest case to reach is a frame that is still open while the other conditions for activity have already gone. Examples are a disable, a ring that has drained, or start and commit pulses arriving in the same cycle. The stimulus reaches this state in three steps: it opens a frame with a single-cycle start pulse, then withdraws the enable or moves the consume index onto the produce index, and finally issues the commit pulse. The output is checked at each edge along the way. The receive wrap case uses a consume index of zero with two ring lengths, so that an incorrect modulus gives a different answer.

// File: rtl/chan_pkg.sv
package chan_pkg;
   typedef enum logic {CH_TX = 1'b0, CH_RX = 1'b1} ch_dir_e;
endpackage

// File: rtl/ring_occupancy.sv
module ring_occupancy #(
   parameter chan_pkg::ch_dir_e DIR = chan_pkg::CH_TX,
   parameter int unsigned IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] prod_idx,
   input  logic [IDX_W-1:0] cons_idx,
   input  logic [IDX_W:0]   ring_len,
   output logic             ring_ok
);
   localparam int unsigned CNT_W = IDX_W + 1;

   generate
      if (DIR == chan_pkg::CH_TX) begin : g_tx
         // transmit: work pending while the ring is not empty
         assign ring_ok = (prod_idx != cons_idx);
      end else begin : g_rx
         // receive: room left while produce has not reached consume-1
         logic [CNT_W-1:0] last_slot;
         logic [IDX_W-1:0] cons_prev;
         assign last_slot = ring_len - CNT_W'(1);
         assign cons_prev = (cons_idx == '0) ? last_slot[IDX_W-1:0]
                                             : cons_idx - IDX_W'(1);
         assign ring_ok   = (prod_idx != cons_prev);

         // an empty ring is never full (ring_len >= 2)
         assert_rx_empty_ok_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (prod_idx == cons_idx && ring_len >= CNT_W'(2)) |-> ring_ok);
      end
   endgenerate
endmodule

// File: rtl/frame_latch.sv
module frame_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_start,
   input  logic frame_commit,
   output logic open_q,
   output logic open_d
);
   // start wins over commit: a new frame begins as the old one closes
   assign open_d = frame_start | (open_q & ~frame_commit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) open_q <= 1'b0;
      else        open_q <= open_d;
   end

   assert_start_opens_R5: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> open_q);
   assert_commit_closes_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_commit && !frame_start) |=> !open_q);
endmodule

// File: rtl/aligned_base_reg.sv
module aligned_base_reg #(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned ALIGN_BITS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] wdata,
   output logic [ADDR_W-1:0] base
);
   localparam int unsigned KEEP_W = ADDR_W - ALIGN_BITS;

   generate
      if (ALIGN_BITS == 0 || ALIGN_BITS >= ADDR_W) begin : g_bad_align
         $error("aligned_base_reg: ALIGN_BITS out of range");
      end
   endgenerate

   logic [KEEP_W-1:0] hi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  hi_q <= '0;
      else if (we) hi_q <= wdata[ADDR_W-1:ALIGN_BITS];
   end

   assign base = {hi_q, {ALIGN_BITS{1'b0}}};

   // R8 and R9: a write lands with its low bits cleared
   assert_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (base[ADDR_W-1:ALIGN_BITS] == $past(wdata[ADDR_W-1:ALIGN_BITS])));
   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(base));
endmodule

// File: rtl/ring_chan_status.sv
module ring_chan_status #(
   parameter chan_pkg::ch_dir_e DIR = chan_pkg::CH_TX,
   parameter int unsigned IDX_W  = 4,
   parameter int unsigned ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_enable,
   input  logic [IDX_W-1:0]  prod_idx,
   input  logic [IDX_W-1:0]  cons_idx,
   input  logic [IDX_W:0]    ring_len,
   input  logic              frame_start,
   input  logic              frame_commit,
   input  logic              desc_base_we,
   input  logic              stat_base_we,
   input  logic [ADDR_W-1:0] base_wdata,
   output logic              chan_active,
   output logic              in_frame,
   output logic [ADDR_W-1:0] desc_base,
   output logic [ADDR_W-1:0] stat_base
);
   localparam int unsigned DESC_ALIGN = 2;
   localparam int unsigned STAT_ALIGN = 3;

   generate
      if (IDX_W < 1 || IDX_W > 16) begin : g_bad_idx
         $error("ring_chan_status: IDX_W out of range");
      end
      if (ADDR_W <= STAT_ALIGN) begin : g_bad_addr
         $error("ring_chan_status: ADDR_W too small");
      end
   endgenerate

   logic ring_ok;
   logic open_d;
   logic active_d;

   ring_occupancy #(.DIR(DIR), .IDX_W(IDX_W)) u_occ (
      .clk(clk), .rst_n(rst_n), .prod_idx(prod_idx), .cons_idx(cons_idx),
      .ring_len(ring_len), .ring_ok(ring_ok));

   frame_latch u_frm (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
      .frame_commit(frame_commit), .open_q(in_frame), .open_d(open_d));

   aligned_base_reg #(.ADDR_W(ADDR_W), .ALIGN_BITS(DESC_ALIGN)) u_desc (
      .clk(clk), .rst_n(rst_n), .we(desc_base_we), .wdata(base_wdata),
      .base(desc_base));

   aligned_base_reg #(.ADDR_W(ADDR_W), .ALIGN_BITS(STAT_ALIGN)) u_stat (
      .clk(clk), .rst_n(rst_n), .we(stat_base_we), .wdata(base_wdata),
      .base(stat_base));

   // running while enabled with ring room/work, or while a frame is open
   assign active_d = (sw_enable & ring_ok) | open_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chan_active <= 1'b0;
      else        chan_active <= active_d;
   end

   assert_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!sw_enable && !frame_start && !in_frame) |=> !chan_active);
   assert_frame_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_frame && !frame_commit) |=> chan_active);
   assert_start_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> chan_active);
endmodule

// File: tb/sim_ring_chan_status.sv
module sim_ring_chan_status;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0;
   logic [3:0]  p = '0;
   logic [3:0]  c = '0;
   logic [4:0]  len = 5'd8;
   logic        fs = 1'b0;
   logic        fc = 1'b0;
   logic        dwe = 1'b0;
   logic        swe = 1'b0;
   logic [31:0] wd = '0;
   logic        tx_act, rx_act, tx_frm, rx_frm;
   logic [31:0] dbase, sbase, rx_dbase, rx_sbase;
   int vectors = 0;
   int errors  = 0;
   bit done    = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   ring_chan_status #(.DIR(chan_pkg::CH_TX), .IDX_W(4), .ADDR_W(32)) u0 (
      .clk(clk), .rst_n(rst_n), .sw_enable(en), .prod_idx(p), .cons_idx(c),
      .ring_len(len), .frame_start(fs), .frame_commit(fc),
      .desc_base_we(dwe), .stat_base_we(swe), .base_wdata(wd),
      .chan_active(tx_act), .in_frame(tx_frm), .desc_base(dbase), .stat_base(sbase));

   ring_chan_status #(.DIR(chan_pkg::CH_RX), .IDX_W(4), .ADDR_W(32)) u1 (
      .clk(clk), .rst_n(rst_n), .sw_enable(en), .prod_idx(p), .cons_idx(c),
      .ring_len(len), .frame_start(fs), .frame_commit(fc),
      .desc_base_we(1'b0), .stat_base_we(1'b0), .base_wdata(wd),
      .chan_active(rx_act), .in_frame(rx_frm), .desc_base(rx_dbase), .stat_base(rx_sbase));

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   // inputs are set just after a falling edge; sample 5 ns past the next rising edge
   task automatic tick();
      @(posedge clk); #5;
   endtask

   task automatic drive(input logic e, input logic [3:0] pi, input logic [3:0] ci);
      @(negedge clk);
      en = e; p = pi; c = ci;
   endtask

   task automatic pulse_start();
      @(negedge clk); fs = 1'b1; tick(); @(negedge clk); fs = 1'b0;
   endtask

   task automatic test_reset();
      #5;
      chk({31'b0, tx_act}, 0, "R1 tx active in reset");
      chk({31'b0, rx_act}, 0, "R1 rx active in reset");
      chk({31'b0, tx_frm}, 0, "R1 in_frame in reset");
      chk(dbase, 0, "R1 desc base");
      chk(sbase, 0, "R1 stat base");
      @(negedge clk); rst_n = 1'b1;
      tick();
      chk({31'b0, tx_act}, 0, "R1 tx active after release");
   endtask

   task automatic test_tx_ring();
      len = 5'd8;
      drive(1, 3, 3); tick();
      chk({31'b0, tx_act}, 0, "R2 tx empty ring");
      drive(1, 4, 3); tick();
      chk({31'b0, tx_act}, 1, "R2 tx work pending");
      drive(1, 3, 3); #3;
      chk({31'b0, tx_act}, 1, "R11 output held before edge");
      tick();
      chk({31'b0, tx_act}, 0, "R2 tx empty again");
   endtask

   task automatic test_rx_ring();
      len = 5'd8;
      drive(1, 4, 5); tick();
      chk({31'b0, rx_act}, 0, "R3 rx full");
      drive(1, 5, 5); tick();
      chk({31'b0, rx_act}, 1, "R3 rx empty ring has room");
      chk({31'b0, tx_act}, 0, "R2 tx same indices empty");
      drive(1, 7, 0); tick();
      chk({31'b0, rx_act}, 0, "R3 rx full at wrap len 8");
      drive(1, 6, 0); tick();
      chk({31'b0, rx_act}, 1, "R3 rx room at wrap len 8");
      @(negedge clk); len = 5'd16; p = 4'd15; c = 4'd0; tick();
      chk({31'b0, rx_act}, 0, "R3 rx full at wrap len 16");
      @(negedge clk); p = 4'd7; tick();
      chk({31'b0, rx_act}, 1, "R3 rx room len 16 p7 c0");
      len = 5'd8;
   endtask

   task automatic test_disable();
      drive(1, 4, 3); tick();
      chk({31'b0, tx_act}, 1, "R4 tx active before disable");
      chk({31'b0, rx_act}, 1, "R4 rx active before disable");
      drive(0, 4, 3); tick();
      chk({31'b0, tx_act}, 0, "R4 tx idle after disable");
      chk({31'b0, rx_act}, 0, "R4 rx idle after disable");
   endtask

   task automatic test_frame_hold();
      drive(1, 4, 3); tick();
      pulse_start();
      drive(0, 4, 3); tick(); tick();
      chk({31'b0, tx_act}, 1, "R5 tx held by open frame");
      chk({31'b0, rx_act}, 1, "R5 rx held by open frame");
      chk({31'b0, tx_frm}, 1, "R5 in_frame set");
      @(negedge clk); fc = 1'b1; tick();
      chk({31'b0, tx_act}, 0, "R6 tx drops at commit");
      chk({31'b0, tx_frm}, 0, "R6 in_frame cleared");
      @(negedge clk); fc = 1'b0;
      // start and commit together keep the frame open
      @(negedge clk); fs = 1'b1; fc = 1'b1; tick();
      @(negedge clk); fs = 1'b0; fc = 1'b0; tick();
      chk({31'b0, tx_act}, 1, "R6 start+commit keeps active");
      chk({31'b0, tx_frm}, 1, "R6 start+commit keeps frame open");
      @(negedge clk); fc = 1'b1; tick();
      @(negedge clk); fc = 1'b0;
      chk({31'b0, tx_act}, 0, "R6 idle after final commit");
   endtask

   task automatic test_tx_drain();
      drive(1, 4, 3); tick();
      pulse_start();
      drive(1, 4, 4); tick(); tick();
      chk({31'b0, tx_act}, 1, "R7 tx held while ring drained");
      @(negedge clk); fc = 1'b1; tick();
      chk({31'b0, tx_act}, 0, "R7 tx drops at commit on empty ring");
      @(negedge clk); fc = 1'b0;
   endtask

   task automatic test_bases();
      @(negedge clk); wd = 32'hDEAD_BEEF; dwe = 1'b1; tick();
      @(negedge clk); dwe = 1'b0;
      chk(dbase, 32'hDEAD_BEEC, "R8 desc base masked");
      chk(sbase, 32'h0, "R10 stat base untouched");
      @(negedge clk); wd = 32'h1234_5677; swe = 1'b1; tick();
      @(negedge clk); swe = 1'b0;
      chk(sbase, 32'h1234_5670, "R9 stat base masked");
      chk(dbase, 32'hDEAD_BEEC, "R10 desc base untouched");
      @(negedge clk); wd = 32'hFFFF_FFFF; tick(); tick();
      chk(dbase, 32'hDEAD_BEEC, "R10 desc holds without write");
      chk(sbase, 32'h1234_5670, "R10 stat holds without write");
      @(negedge clk); dwe = 1'b1; tick();
      @(negedge clk); dwe = 1'b0;
      chk(dbase, 32'hFFFF_FFFC, "R8 desc all ones");
   endtask

   initial begin
      test_reset();
      test_tx_ring();
      test_rx_ring();
      test_disable();
      test_frame_hold();
      test_tx_drain();
      test_bases();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end
endmodule